// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the element address stream for a single DMA channel. Software programs a base address, a row length with its element stride, and a row count with its row-to-row stride. It then writes a control word that starts the channel. The generator presents one address at a time under a valid/ready handshake. The bus master that moves the data consumes these addresses and sits outside the block.

Both strides are signed and independent. The row-to-row stride may be smaller than the element stride, or negative, so a single channel can walk interleaved streams apart. A one-dimensional transfer uses only the row length and the element stride.

In stop mode the channel halts after the last element. In autobuffer mode it reloads the base address and both counters and runs on until software stops it. A one-cycle row pulse and frame pulse mark completions. The interrupt output follows one of the two, as the control word selects.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it rises until a start is written, valid_o, busy_o, row_done_o, frame_done_o and irq_o are all low.
- R2: A write to register select 5 with wdata bit 0 set starts the channel. In the next cycle valid_o and busy_o are high and addr_o equals the last value written to register select 0.
- R3: The address advances only in a cycle where valid_o and ready_i are both high. While ready_i is low, addr_o and valid_o hold.
- R4: Within a row, each accepted element adds the signed 16-bit element stride (select 2) times the element size. Control bits [5:4] give the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is also 4 bytes.
- R5: After the last element of a row, the address adds the signed 16-bit row stride (select 4) times the element size. This holds even when the row stride is smaller than the element stride or negative.
- R6: With control bit 1 (two-dimensional) clear, the row count (select 3) and row stride are ignored, and a frame is a single row.
- R7: A programmed count of zero (select 1 or select 3) means 65536.
- R8: row_done_o is a one-cycle pulse in the cycle after the last element of a row is accepted. frame_done_o pulses in that same cycle when the row is the last row of the frame.
- R9: In stop mode (control bit 2 clear), valid_o and busy_o fall in the cycle after the final element of the frame is accepted.
- R10: In autobuffer mode (control bit 2 set), after the final element the address returns to the base and the counters restart, with valid_o staying high.
- R11: irq_o equals row_done_o when autobuffer mode and control bit 3 are both set. Otherwise irq_o equals frame_done_o.
- R12: A control write with bit 0 clear stops the channel in the next cycle. Writes to selects 0 to 4 while the channel runs do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select: 0 base, 1 row length, 2 element stride, 3 row count, 4 row stride, 5 control |
| cfg_wdata_i | input | 32 | Configuration write data |
| addr_o | output | AW (32) | Current element byte address |
| valid_o | output | 1 | Address is valid |
| ready_i | input | 1 | Consumer accepts the address |
| busy_o | output | 1 | Channel is running |
| row_done_o | output | 1 | One-cycle pulse after the last element of a row |
| frame_done_o | output | 1 | One-cycle pulse after the last element of a frame |
| irq_o | output | 1 | Interrupt, row or frame pulse as selected |

## Verification
Two pairs of events can land in the same cycle. The first is the row end and the frame end: they coincide on the final element of the last row. The bench sweeps row lengths and row counts from 1 to 3, so every geometry hits this coincidence, including the degenerate cases of one element per row and a single row. It checks both pulses and the interrupt against the index computed for each accepted element. The second is the frame end and the autobuffer reload. The bench runs several passes and checks that the address presented right after the final pulse equals the base.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_BASE = 3'd0,
    REG_ICNT = 3'd1,
    REG_ISTR = 3'd2,
    REG_OCNT = 3'd3,
    REG_OSTR = 3'd4,
    REG_CTRL = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] esize;
    logic       irq_row;
    logic       autobuf;
    logic       two_d;
  } mode_t;

  // element size code -> shift amount; code 3 aliases 4 bytes
  function automatic logic [1:0] esize_shift(logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [AW-1:0]    base_o,
  output logic [CW-1:0]    icnt_o,
  output logic [CW-1:0]    istr_o,
  output logic [CW-1:0]    ocnt_o,
  output logic [CW-1:0]    ostr_o,
  output mode_t            mode_o,
  output logic             start_o,
  output logic             stop_o
);
  logic ctrl_wr;

  assign ctrl_wr = we_i && (sel_i == REG_CTRL);
  assign start_o = ctrl_wr && wdata_i[0];
  assign stop_o  = ctrl_wr && !wdata_i[0];

  // mode is taken from the control write itself and latched by the walker
  assign mode_o = '{esize:   wdata_i[5:4],
                    irq_row: wdata_i[3],
                    autobuf: wdata_i[2],
                    two_d:   wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      icnt_o <= '0;
      istr_o <= '0;
      ocnt_o <= '0;
      ostr_o <= '0;
    end else if (we_i) begin
      case (sel_i)
        REG_BASE: base_o <= wdata_i[AW-1:0];
        REG_ICNT: icnt_o <= wdata_i[CW-1:0];
        REG_ISTR: istr_o <= wdata_i[CW-1:0];
        REG_OCNT: ocnt_o <= wdata_i[CW-1:0];
        REG_OSTR: ostr_o <= wdata_i[CW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
  import dma2d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          fire_i,
  input  logic [CW-1:0] icnt_i,
  input  logic [CW-1:0] ocnt_i,
  input  mode_t         mode_i,
  output logic          run_o,
  output mode_t         mode_o,
  output logic          row_end_o,
  output logic          frame_end_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] ilim_q, olim_q, ix_q, iy_q;
  mode_t         mode_q;
  logic          run_q;

  // last index = count - 1; a zero count wraps to all ones (65536 elements)
  assign row_end_o   = (ix_q == ilim_q);
  assign frame_end_o = row_end_o && (iy_q == olim_q);
  assign run_o       = run_q;
  assign mode_o      = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      ilim_q <= '0;
      olim_q <= '0;
      ix_q   <= '0;
      iy_q   <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      mode_q <= mode_i;
      ilim_q <= icnt_i - ONE;
      olim_q <= mode_i.two_d ? (ocnt_i - ONE) : '0;
      ix_q   <= '0;
      iy_q   <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (fire_i && run_q) begin
      if (row_end_o) begin
        ix_q <= '0;
        if (frame_end_o) begin
          iy_q <= '0;
          if (!mode_q.autobuf) run_q <= 1'b0;
        end else begin
          iy_q <= iy_q + ONE;
        end
      end else begin
        ix_q <= ix_q + ONE;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_dp.sv
module dma2d_addr_dp #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fire_i,
  input  logic          row_end_i,
  input  logic          frame_end_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] istr_i,
  input  logic [CW-1:0] ostr_i,
  input  logic [1:0]    shamt_i,
  output logic [AW-1:0] addr_o
);
  localparam int XW = AW - CW;

  logic [AW-1:0] base_q, istep_q, ostep_q, addr_q;

  function automatic logic [AW-1:0] scale(logic [CW-1:0] s, logic [1:0] sh);
    logic [AW-1:0] ext;
    ext = {{XW{s[CW-1]}}, s};
    return ext << sh;
  endfunction

  assign addr_o = addr_q;

  // steps are scaled once at start so the per-element path is a single add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      istep_q <= '0;
      ostep_q <= '0;
      addr_q  <= '0;
    end else if (start_i) begin
      base_q  <= base_i;
      istep_q <= scale(istr_i, shamt_i);
      ostep_q <= scale(ostr_i, shamt_i);
      addr_q  <= base_i;
    end else if (fire_i) begin
      if (frame_end_i)    addr_q <= base_q;
      else if (row_end_i) addr_q <= addr_q + ostep_q;
      else                addr_q <= addr_q + istep_q;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [AW-1:0]    addr_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             row_done_o,
  output logic             frame_done_o,
  output logic             irq_o
);
  logic [AW-1:0] base_w;
  logic [CW-1:0] icnt_w, istr_w, ocnt_w, ostr_w;
  mode_t         wr_mode, run_mode;
  logic          start_w, stop_w, run_w, row_end_w, frame_end_w, fire_w;
  logic          run_ab, row_q, frame_q, irq_q;

  dma2d_cfg_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base_w),
    .icnt_o  (icnt_w),
    .istr_o  (istr_w),
    .ocnt_o  (ocnt_w),
    .ostr_o  (ostr_w),
    .mode_o  (wr_mode),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  dma2d_walk #(.CW(CW)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .fire_i      (fire_w),
    .icnt_i      (icnt_w),
    .ocnt_i      (ocnt_w),
    .mode_i      (wr_mode),
    .run_o       (run_w),
    .mode_o      (run_mode),
    .row_end_o   (row_end_w),
    .frame_end_o (frame_end_w)
  );

  dma2d_addr_dp #(.AW(AW), .CW(CW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .fire_i      (fire_w),
    .row_end_i   (row_end_w),
    .frame_end_i (frame_end_w),
    .base_i      (base_w),
    .istr_i      (istr_w),
    .ostr_i      (ostr_w),
    .shamt_i     (esize_shift(wr_mode.esize)),
    .addr_o      (addr_o)
  );

  assign fire_w = run_w && ready_i;
  assign run_ab = run_mode.autobuf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= 1'b0;
      frame_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      row_q   <= fire_w && row_end_w;
      frame_q <= fire_w && frame_end_w;
      irq_q   <= fire_w && ((run_ab && run_mode.irq_row) ? row_end_w : frame_end_w);
    end
  end

  assign valid_o      = run_w;
  assign busy_o       = run_w;
  assign row_done_o   = row_q;
  assign frame_done_o = frame_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          start_wr_i,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          ready_i,
  input logic          row_done_o,
  input logic          frame_done_o,
  input logic          irq_o,
  input logic          run_ab_i
);
  assert_start_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |=> valid_o);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !cfg_we_i) |=> (valid_o && $stable(addr_o)));

  assert_row_after_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |-> $past(valid_o && ready_i));

  assert_frame_with_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> row_done_o);

  assert_stop_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && !run_ab_i && !$past(cfg_we_i)) |-> !valid_o);

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> row_done_o);

  assert_frame_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> irq_o);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .start_wr_i   (cfg_we_i && (cfg_sel_i == dma2d_pkg::REG_CTRL) && cfg_wdata_i[0]),
  .addr_o       (addr_o),
  .valid_o      (valid_o),
  .ready_i      (ready_i),
  .row_done_o   (row_done_o),
  .frame_done_o (frame_done_o),
  .irq_o        (irq_o),
  .run_ab_i     (run_ab)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] addr_o;
  logic        valid_o, busy_o, row_done_o, frame_done_o, irq_o;
  logic        ready_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  dma2d_addr_gen u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .addr_o       (addr_o),
    .valid_o      (valid_o),
    .ready_i      (ready_i),
    .busy_o       (busy_o),
    .row_done_o   (row_done_o),
    .frame_done_o (frame_done_o),
    .irq_o        (irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cfg_wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] base, longint k, longint eic,
                                           longint eoc, longint is, longint os, int code);
    longint m, x, y, esz, off;
    m   = k % (eic * eoc);
    y   = m / eic;
    x   = m % eic;
    esz = (code >= 2) ? 4 : (1 << code);
    off = esz * (y * ((eic - 1) * is + os) + x * is);
    return base + off[31:0];
  endfunction

  function automatic logic rdy_pat(int c, int md);
    case (md)
      0:       return (c % 3) != 1;
      1:       return (c % 4) < 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_case(logic [31:0] base, int ic, int is, int oc, int os, int code,
                          bit two_d, bit ab, bit irq_row, int passes, int md, bit poke);
    longint eic, eoc, total, k;
    bit exp_row, exp_frm, exp_irq, xl, yl;
    eic = (ic == 0) ? 65536 : ic;
    eoc = !two_d ? 1 : ((oc == 0) ? 65536 : oc);
    total = eic * eoc * passes;
    ready_i = 1'b0;
    cfg_wr(3'd0, base);
    cfg_wr(3'd1, 32'(ic & 16'hFFFF));
    cfg_wr(3'd2, 32'(is & 16'hFFFF));
    cfg_wr(3'd3, 32'(oc & 16'hFFFF));
    cfg_wr(3'd4, 32'(os & 16'hFFFF));
    cfg_wr(3'd5, {26'd0, 2'(code), irq_row, ab, two_d, 1'b1});
    chk(valid_o == 1'b1 && busy_o == 1'b1, "R2 valid after start", valid_o, 1);
    chk(addr_o == base, "R2 first address", addr_o, base);
    k = 0; exp_row = 0; exp_frm = 0; exp_irq = 0;
    while (k < total) begin
      chk(row_done_o == exp_row, "R8 row_done", row_done_o, exp_row);
      chk(frame_done_o == exp_frm, "R8 frame_done", frame_done_o, exp_frm);
      chk(irq_o == exp_irq, "R11 irq", irq_o, exp_irq);
      chk(valid_o == 1'b1, "R3 valid held", valid_o, 1);
      chk(addr_o == exp_addr(base, k, eic, eoc, is, os, code),
          two_d ? "R5 R4 address" : "R6 R4 address",
          addr_o, exp_addr(base, k, eic, eoc, is, os, code));
      cyc++;
      ready_i = rdy_pat(cyc, md);
      if (poke && k == 1) begin
        cfg_we_i = 1'b1; cfg_sel_i = 3'd0; cfg_wdata_i = 32'hDEAD_0000;
      end else begin
        cfg_we_i = 1'b0;
      end
      exp_row = 0; exp_frm = 0; exp_irq = 0;
      if (ready_i) begin
        xl = ((k % eic) == eic - 1);
        yl = (((k % (eic * eoc)) / eic) == eoc - 1);
        exp_row = xl;
        exp_frm = xl && yl;
        exp_irq = (ab && irq_row) ? exp_row : exp_frm;
        k++;
      end
      @(negedge clk_i);
    end
    cfg_we_i = 1'b0;
    chk(row_done_o == exp_row, "R8 final row_done", row_done_o, exp_row);
    chk(frame_done_o == exp_frm, "R8 final frame_done", frame_done_o, exp_frm);
    chk(irq_o == exp_irq, "R11 final irq", irq_o, exp_irq);
    ready_i = 1'b0;
    if (!ab) begin
      chk(valid_o == 1'b0, "R9 valid low after frame", valid_o, 0);
      chk(busy_o == 1'b0, "R9 busy low after frame", busy_o, 0);
    end else begin
      chk(valid_o == 1'b1, "R10 still running", valid_o, 1);
      chk(addr_o == base, "R10 reload base", addr_o, base);
      cfg_we_i = 1'b1; cfg_sel_i = 3'd5; cfg_wdata_i = 32'h0;
      @(negedge clk_i);
      cfg_we_i = 1'b0;
      chk(valid_o == 1'b0 && busy_o == 1'b0, "R12 stop write halts", valid_o, 0);
    end
    @(negedge clk_i);
    chk(row_done_o == 1'b0 && frame_done_o == 1'b0, "R8 no stray pulse", row_done_o, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && busy_o == 1'b0, "R1 reset idle", valid_o, 0);
    chk(row_done_o == 1'b0 && frame_done_o == 1'b0 && irq_o == 1'b0,
        "R1 reset pulses", irq_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(valid_o == 1'b0 && busy_o == 1'b0, "R1 idle after reset", valid_o, 0);

    // sweep geometry and strides, including row stride below element stride (R5)
    for (int ic = 1; ic <= 3; ic++)
      for (int oc = 1; oc <= 3; oc++)
        for (int p = 0; p < 3; p++) begin
          int is_v, os_v;
          is_v = (p == 0) ? 1 : (p == 1) ? 2 : 3;
          os_v = (p == 0) ? 1 : (p == 1) ? -3 : -7;
          run_case(32'h1000_0000 + 32'(ic * 256 + oc * 16), ic, is_v, oc, os_v, p,
                   1'b1, 1'b0, 1'b0, 1, (ic + oc) % 2, 1'b0);
        end

    // R6: one-dimensional mode ignores row count/stride; code 3 acts as 4 bytes (R4)
    run_case(32'h2000_0000, 5, 2, 7, 99, 3, 1'b0, 1'b0, 1'b0, 1, 0, 1'b0);
    // R10 R11 R12: autobuffer, frame irq, base rewritten mid-run
    run_case(32'h3000_0040, 3, 1, 2, 4, 0, 1'b1, 1'b1, 1'b0, 2, 1, 1'b1);
    // R10 R11: autobuffer with row irq, negative element stride
    run_case(32'h3100_0100, 2, -2, 3, 10, 1, 1'b1, 1'b1, 1'b1, 2, 0, 1'b0);
    // R10: one-dimensional autobuffer, three passes
    run_case(32'h3200_0000, 4, 5, 0, 0, 2, 1'b0, 1'b1, 1'b1, 3, 1, 1'b0);
    // R7: zero row length means 65536 elements
    run_case(32'h4000_0000, 0, 1, 1, 0, 0, 1'b0, 1'b0, 1'b0, 1, 2, 1'b0);

    summary();
    $finish;
  end
endmodule